// File: doc/BRIEF.md
# Branch Target Address Cache

This block is a small, fully associative table consulted by an instruction fetch stage on every cycle. Each entry remembers the address of a control-transfer instruction seen earlier, the most recent address it transferred to, whether it is an unconditional jump, and a 2-bit saturating direction counter. The fetch stage presents its current PC on the lookup port. One cycle later the block reports whether the PC was found, whether the entry is a jump, whether a transfer is predicted, and the predicted next PC. The predicted next PC is the stored target when a transfer is predicted, and otherwise the sequential address.

A later pipeline stage reports each resolved branch or jump on the resolve port. The block then creates, refreshes or removes the matching entry. A mode input selects between two policies. In the static policy only taken branches stay in the table, and a branch that resolves not-taken is evicted. In the dynamic policy a branch keeps its entry and its target while its counter moves towards not-taken, so that a later turn back to taken finds the target still there. New entries fill the lowest free slot. Once the table is full, a round-robin pointer picks the slot to overwrite.

Top module: `btac_top`

## Requirements
- R1: While `rst` is high, and on the first output cycle after reset, `lk_hit`, `lk_jump` and `lk_taken` are 0 and `pred_npc` is 0. Reset empties the table, so any PC looked up afterwards misses until it is resolved again.
- R2: The outputs for a PC presented on `lk_pc` before clock edge k appear after edge k. On a miss `lk_hit`, `lk_jump` and `lk_taken` are 0 and `pred_npc` equals `lk_pc + INSN_BYTES` (default 4), with the sum wrapping modulo 2^AW.
- R3: A hit on a jump entry gives `lk_hit`=1, `lk_jump`=1, `lk_taken`=1, and `pred_npc` equal to the stored target.
- R4: A hit on a branch entry gives `lk_jump`=0 and `lk_taken` equal to bit 1 of its counter (counter values 0 to 3, where 2 and 3 mean taken). `pred_npc` is the stored target when the branch is predicted taken, and `lk_pc + INSN_BYTES` when it is not.
- R5: A resolved jump, or a resolved taken branch, whose PC is not in the table is written into the table. A new branch entry starts with counter value 2. A not-taken branch that misses allocates nothing. A PC is never held in more than one entry.
- R6: With `dyn_mode`=0, a taken branch that hits rewrites the target and sets the counter to 2. A not-taken branch that hits removes the entry.
- R7: With `dyn_mode`=1, a resolved branch that hits moves its counter up by one (taken) or down by one (not-taken), saturating at 3 and at 0, and marks the entry as a branch. The target is rewritten only when the branch is taken, so a not-taken resolution keeps both the entry and its old target.
- R8: A resolved jump that hits an existing entry, whether that entry holds a jump or a branch, rewrites the target and marks the entry as a jump.
- R9: An allocation uses the lowest-numbered free slot. When all slots are valid, it overwrites the slot named by a pointer. The pointer starts at 0 after reset, advances by one (wrapping) after each such overwrite, and does not move when a free slot is filled.
- R10: A resolve and a lookup in the same cycle do not interact: the lookup reports the table as it was before the resolve, and the change is visible to the lookup in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dyn_mode | input | 1 | 1 selects the dynamic policy, 0 selects the static taken-only policy |
| lk_pc | input | AW | PC looked up this cycle |
| upd_valid | input | 1 | A resolved control transfer is presented this cycle |
| upd_pc | input | AW | Address of the resolved instruction |
| upd_taken | input | 1 | The resolved branch was taken |
| upd_jump | input | 1 | The resolved instruction is an unconditional jump |
| upd_target | input | AW | Resolved target address |
| lk_hit | output | 1 | Registered: the looked-up PC was in the table |
| lk_jump | output | 1 | Registered: the hit entry is a jump |
| lk_taken | output | 1 | Registered: a transfer is predicted |
| pred_npc | output | AW | Registered: predicted next fetch address |

## Verification
The lookup path is tried with addresses that were never resolved, with jump entries, and with branch entries whose counters are walked through every value in both directions, including repeated steps at each end. This separates correct counter saturation and target retention from wrap-around or from a target overwritten on a not-taken resolution. The same branch is resolved under each policy, which separates eviction from counter decay, and resolves are issued in the same cycle as a lookup of the same PC to expose any bypass. A fill-and-overflow sequence with an eviction in the middle separates lowest-free-slot filling from pointer-driven replacement. A reset in the middle of the run shows that the table is emptied.

// File: rtl/btac_pkg.sv
`timescale 1ns/1ps
package btac_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN   = 2'd2;
  localparam ctr_t CTR_STRONG_TAKEN = 2'd3;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == CTR_STRONG_TAKEN) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btac_match.sv
`timescale 1ns/1ps
module btac_match #(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic [AW-1:0]      tags [ENTRIES],
  input  logic [AW-1:0]      key,
  output logic               hit,
  output logic [IW-1:0]      idx
);
  logic [ENTRIES-1:0] eq_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (eq_vec[i]) idx = idx | IW'(i);
    end
  end

  assign hit = |eq_vec;

  // R5: a PC never occupies two entries
  p_unique_tag_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(eq_vec));
endmodule

// File: rtl/btac_victim.sv
`timescale 1ns/1ps
module btac_victim #(
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               alloc,
  output logic [IW-1:0]      victim
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] free_idx;
  logic          free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign victim = free_found ? free_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (alloc && !free_found)
      ptr_q <= (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R9: the pointer moves only after an overwrite of a full table
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (ptr_q != $past(ptr_q)) |-> $past(alloc && !free_found));
endmodule

// File: rtl/btac_top.sv
`timescale 1ns/1ps
module btac_top #(
  parameter int AW         = 32,
  parameter int ENTRIES    = 8,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dyn_mode,
  input  logic [AW-1:0] lk_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic          upd_jump,
  input  logic [AW-1:0] upd_target,
  output logic          lk_hit,
  output logic          lk_jump,
  output logic          lk_taken,
  output logic [AW-1:0] pred_npc
);
  import btac_pkg::*;

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AW-1:0] NEXT_STEP = AW'(INSN_BYTES);

  // table storage: valid bits reset, payload left as plain memory
  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      tag_q   [ENTRIES];
  logic [AW-1:0]      tgt_mem [ENTRIES];
  logic [ENTRIES-1:0] jmp_q;
  ctr_t               ctr_q   [ENTRIES];

  // lookup side
  logic          lk_hit_c;
  logic [IW-1:0] lk_idx;
  logic          lk_jmp_c, lk_tk_c;
  logic [AW-1:0] npc_c;

  btac_match #(.AW(AW), .ENTRIES(ENTRIES)) u_lk_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q),
    .key(lk_pc), .hit(lk_hit_c), .idx(lk_idx)
  );

  assign lk_jmp_c = lk_hit_c && jmp_q[lk_idx];
  assign lk_tk_c  = lk_hit_c && (jmp_q[lk_idx] || ctr_q[lk_idx][1]);
  assign npc_c    = lk_tk_c ? tgt_mem[lk_idx] : lk_pc + NEXT_STEP;

  // resolve side
  logic          upd_hit;
  logic [IW-1:0] upd_idx;
  logic [IW-1:0] victim_idx;
  logic [IW-1:0] widx;
  logic          wr_en, wr_tgt, wr_jmp, drop_en, alloc;
  ctr_t          wr_ctr;

  btac_match #(.AW(AW), .ENTRIES(ENTRIES)) u_upd_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q),
    .key(upd_pc), .hit(upd_hit), .idx(upd_idx)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_tgt  = 1'b0;
    wr_jmp  = 1'b0;
    drop_en = 1'b0;
    wr_ctr  = CTR_WEAK_TAKEN;
    if (upd_valid) begin
      if (upd_jump) begin
        wr_en  = 1'b1;
        wr_tgt = 1'b1;
        wr_jmp = 1'b1;
        wr_ctr = CTR_STRONG_TAKEN;
      end else if (upd_taken) begin
        wr_en  = 1'b1;
        wr_tgt = 1'b1;
        wr_ctr = (dyn_mode && upd_hit) ? ctr_step(ctr_q[upd_idx], 1'b1) : CTR_WEAK_TAKEN;
      end else if (upd_hit) begin
        if (dyn_mode) begin
          wr_en  = 1'b1;
          wr_ctr = ctr_step(ctr_q[upd_idx], 1'b0);
        end else begin
          drop_en = 1'b1;
        end
      end
    end
  end

  assign alloc = wr_en && !upd_hit;
  assign widx  = upd_hit ? upd_idx : victim_idx;

  btac_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid(valid_q), .alloc(alloc), .victim(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[widx] <= 1'b1;
    else if (drop_en) valid_q[upd_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[widx] <= upd_pc;
      jmp_q[widx] <= wr_jmp;
      ctr_q[widx] <= wr_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tgt) tgt_mem[widx] <= upd_target;
  end

  // registered lookup result
  logic out_live;
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_jump  <= 1'b0;
      lk_taken <= 1'b0;
      pred_npc <= '0;
      out_live <= 1'b0;
    end else begin
      lk_hit   <= lk_hit_c;
      lk_jump  <= lk_jmp_c;
      lk_taken <= lk_tk_c;
      pred_npc <= npc_c;
      out_live <= 1'b1;
    end
  end

  // R4: a predicted transfer always comes from a hit
  p_taken_needs_hit_r4: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> lk_hit);
  // R3: a jump hit is always predicted taken
  p_jump_taken_r3: assert property (@(posedge clk) disable iff (rst)
    lk_jump |-> (lk_taken && lk_hit));
  // R2: a miss falls through to the sequential address
  p_miss_step_r2: assert property (@(posedge clk) disable iff (rst)
    (out_live && !lk_hit) |-> (pred_npc == $past(lk_pc) + NEXT_STEP));
  // R6: static policy evicts a branch that resolves not-taken
  p_static_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_jump && !upd_taken && !dyn_mode && upd_hit)
      |=> !valid_q[$past(upd_idx)]);
endmodule

// File: tb/sim_btac_top.sv
`timescale 1ns/1ps
module sim_btac_top;
  localparam int AW = 32;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dyn_mode = 1'b1;
  logic [AW-1:0] lk_pc = '0;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic          upd_jump = 1'b0;
  logic [AW-1:0] upd_target = '0;
  logic          lk_hit, lk_jump, lk_taken;
  logic [AW-1:0] pred_npc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  btac_top #(.AW(AW), .ENTRIES(N), .INSN_BYTES(4)) u0 (
    .clk(clk), .rst(rst), .dyn_mode(dyn_mode), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_jump(upd_jump), .upd_target(upd_target),
    .lk_hit(lk_hit), .lk_jump(lk_jump), .lk_taken(lk_taken), .pred_npc(pred_npc)
  );

  // behavioural reference table
  bit       m_v   [N];
  bit [31:0] m_tag [N];
  bit [31:0] m_tgt [N];
  bit       m_j   [N];
  int       m_ctr [N];
  int       m_ptr;

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0;
  endfunction

  function automatic int m_find(bit [31:0] pc);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic m_look(input bit [31:0] pc, output bit h, output bit j, output bit t,
                        output bit [31:0] n);
    int k = m_find(pc);
    h = (k >= 0);
    j = h && m_j[k];
    t = h && (m_j[k] || m_ctr[k] >= 2);
    n = t ? m_tgt[k] : pc + 32'd4;
  endtask

  task automatic m_upd(input bit [31:0] pc, input bit tk, input bit jp, input bit [31:0] tg);
    int k = m_find(pc);
    bit wr = 0;
    int nc = 2;
    if (jp) begin wr = 1; nc = 3; end
    else if (tk) begin
      wr = 1;
      nc = (dyn_mode && k >= 0) ? ((m_ctr[k] == 3) ? 3 : m_ctr[k] + 1) : 2;
    end else if (k >= 0) begin
      if (dyn_mode) begin
        m_ctr[k] = (m_ctr[k] == 0) ? 0 : m_ctr[k] - 1;
        m_j[k] = 0;
      end else m_v[k] = 0;
    end
    if (wr) begin
      if (k < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
        if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % N; end
      end
      m_v[k] = 1; m_tag[k] = pc; m_tgt[k] = tg; m_j[k] = jp; m_ctr[k] = nc;
    end
  endtask

  // one clock: drive at negedge, predict, advance model, compare at next negedge
  task automatic cyc(input bit [31:0] pc, input bit uv, input bit [31:0] upc,
                     input bit ut, input bit uj, input bit [31:0] utg, input string req);
    bit eh, ej, et;
    bit [31:0] en;
    lk_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_jump = uj; upd_target = utg;
    m_look(pc, eh, ej, et, en);
    if (uv) m_upd(upc, ut, uj, utg);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 0;
    checks++;
    if (lk_hit !== eh || lk_jump !== ej || lk_taken !== et || pred_npc !== en) begin
      failures++;
      $display("FAIL %s pc=%h: got hit=%0b jump=%0b taken=%0b npc=%h, expected hit=%0b jump=%0b taken=%0b npc=%h",
               req, pc, lk_hit, lk_jump, lk_taken, pred_npc, eh, ej, et, en);
    end
  endtask

  task automatic look(input bit [31:0] pc, input string req);
    cyc(pc, 0, 0, 0, 0, 0, req);
  endtask

  task automatic br(input bit [31:0] pc, input bit tk, input bit [31:0] tg, input string req);
    cyc(pc, 1, pc, tk, 0, tg, req);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) look(32'h1000 + 32'(16 * i), req);
    for (int j = 0; j < 4; j++) look(32'h2000 + 32'(16 * j), req);
  endtask

  task automatic do_reset();
    rst = 1; upd_valid = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (lk_hit !== 0 || lk_jump !== 0 || lk_taken !== 0 || pred_npc !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs: got hit=%0b jump=%0b taken=%0b npc=%h, expected all 0",
               lk_hit, lk_jump, lk_taken, pred_npc);
    end
    m_clear();
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_clear();
    @(negedge clk);
    do_reset();
    dyn_mode = 1;
    look(32'h100, "R1");
    look(32'hFFFF_FFFC, "R2");
    // R10: resolve and lookup of the same PC in one cycle
    br(32'h100, 1, 32'h200, "R10");
    look(32'h100, "R5");
    cyc(32'h300, 1, 32'h300, 1, 1, 32'h800, "R10");
    look(32'h300, "R3");
    // R7: counter walks down, saturates at 0, target kept
    br(32'h100, 0, 32'h999, "R7");
    look(32'h100, "R7");
    br(32'h100, 0, 32'h999, "R7");
    br(32'h100, 0, 32'h999, "R7");
    look(32'h100, "R7");
    br(32'h100, 1, 32'h240, "R7");
    look(32'h100, "R4");
    br(32'h100, 1, 32'h240, "R7");
    look(32'h100, "R4");
    br(32'h100, 1, 32'h240, "R7");
    br(32'h100, 1, 32'h240, "R7");
    br(32'h100, 0, 32'h999, "R7");
    look(32'h100, "R7");
    // R5: not-taken miss allocates nothing
    br(32'h500, 0, 32'h900, "R5");
    look(32'h500, "R5");
    // R8: jump overwrites a branch entry
    cyc(32'h100, 1, 32'h100, 1, 1, 32'h700, "R8");
    look(32'h100, "R8");
    cyc(32'h300, 1, 32'h300, 1, 1, 32'h880, "R8");
    look(32'h300, "R8");
    // R6: static policy refresh and eviction
    dyn_mode = 0;
    br(32'h600, 1, 32'h640, "R6");
    look(32'h600, "R6");
    br(32'h600, 1, 32'h680, "R6");
    look(32'h600, "R6");
    br(32'h600, 0, 32'h604, "R6");
    look(32'h600, "R6");
    look(32'h300, "R6");
    // R1: reset in mid-run empties the table
    do_reset();
    look(32'h100, "R1");
    look(32'h300, "R1");
    // R9: fill and overflow
    for (int i = 0; i < 8; i++) br(32'h1000 + 32'(16 * i), 1, 32'h5000 + 32'(16 * i), "R9");
    sweep("R9");
    br(32'h2000, 1, 32'h6000, "R9");
    sweep("R9");
    br(32'h2010, 1, 32'h6010, "R9");
    sweep("R9");
    br(32'h1040, 0, 32'h1044, "R6");
    br(32'h2020, 1, 32'h6020, "R9");
    sweep("R9");
    br(32'h2030, 1, 32'h6030, "R9");
    sweep("R9");
    dyn_mode = 1;
    br(32'h1070, 0, 32'h0, "R7");
    look(32'h1070, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule